// File: doc/BRIEF.md
# Selectable Fractional Clock-Enable Generator

This block produces a single clock-enable pulse stream for one peripheral. Up to sixteen source tick inputs, each a one-cycle enable pulse at its own rate, arrive on a bus. A source field in the control register picks one of them. The picked stream is then slowed by a divider made of an integer part and a fractional part. The result drives one output tick.

Slot 0 is always ground and never ticks. Slot 1 is meant for the main oscillator, and slots 2 and 3 are meant for two test clocks. The remaining slots are wired per instance. A parameter mask ties any unused slot to ground.

The control and divider registers are written through direct write ports and read back through direct read ports. No bus is involved. The integer and fraction widths are instance parameters, with `FRAC_BITS` at most 12 and `12 + INT_BITS` at most 32. Setting both widths to zero builds a plain pass-through variant. Fractional division uses a phase accumulator. Each selected source tick adds 2^FRAC_BITS to it. When the sum reaches the divider value, an output tick fires and the divider value is subtracted.

Top module: `fracclk_gen`

## Requirements
- R1: After reset the control readback is 0x00, the divider readback is 0x00000000 and `tick_o` is low.
- R2: Control readback bit 7 (busy) always equals the stored enable bit 4. Written values of bits 7:5 are ignored, and bits 6:5 read as zero.
- R3: While enable (control bit 4) is clear, `tick_o` stays low whatever the source ticks and the divider are.
- R4: Control bits 3:0 pick which `src_tick_i` bit feeds the divider. Ticks on the other slots have no effect on `tick_o`.
- R5: Slot 0, and every slot whose bit is set in `GND_MASK` (slots 10 to 15 by default), never produces an output tick.
- R6: The divider value D is taken from divider bits `[12+INT_BITS-1 : 12-FRAC_BITS]`, with the integer part starting at bit 12. Other bits are stored and read back but do not affect the output.
- R7: Counting from a phase restart, N selected source ticks give floor(N * 2^FRAC_BITS / D) output ticks when D > 2^FRAC_BITS.
- R8: A divider field of zero stops the output.
- R9: When 0 < D <= 2^FRAC_BITS, every selected source tick gives one output tick.
- R10: An instance with `INT_BITS = FRAC_BITS = 0` passes the selected source through, one output tick per source tick, whatever the divider register holds.
- R11: A divider write, or a control write that changes the source field, clears the phase accumulator. A source tick that falls in the clock cycle just after such a write is dropped.
- R12: An output tick appears in the clock cycle just after the clock edge that samples the source tick that fires it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| src_tick_i | input | 16 | Source tick enables, one per slot |
| ctrl_wr_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 8 | Control write data: bits 3:0 source, bit 4 enable |
| div_wr_i | input | 1 | Divider register write strobe |
| div_wdata_i | input | 32 | Divider write data |
| ctrl_rdata_o | output | 8 | Control readback, with busy at bit 7 |
| div_rdata_o | output | 32 | Divider readback |
| tick_o | output | 1 | Generated output tick enable |

## Verification
A corrupted accumulator shows up as a wrong output count within one divider period after a restart. For that reason the rate tests count outputs over whole periods from a known restart point, so a phase that carried over or was lost changes the total. A wrong enable or source register shows up in the readback one cycle after the write, and as stray or missing ticks on the very next source pulse. The bypass instance exposes any accidental dependence on the divider in the zero-width case on the first tick.

// File: rtl/fracclk_pkg.sv
package fracclk_pkg;
  localparam int SEL_W     = 4;
  localparam int CTRL_W    = 8;
  localparam int EN_BIT    = 4;
  localparam int BUSY_BIT  = 7;
  localparam int DIV_W     = 32;
  localparam int INT_LSB   = 12;

  typedef struct packed {
    logic             en;
    logic [SEL_W-1:0] sel;
  } ctrl_fields_t;
endpackage

// File: rtl/fracclk_regs.sv
module fracclk_regs
  import fracclk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  input  logic              div_wr_i,
  input  logic [DIV_W-1:0]  div_wdata_i,
  output ctrl_fields_t      ctrl_o,
  output logic [DIV_W-1:0]  div_o,
  output logic              restart_o,
  output logic [CTRL_W-1:0] ctrl_rdata_o
);
  ctrl_fields_t     ctrl_q, ctrl_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic             restart_q, restart_d;

  // next-state logic with written-out enables
  always_comb begin
    ctrl_d    = ctrl_q;
    div_d     = div_q;
    restart_d = 1'b0;
    if (ctrl_wr_i) begin
      ctrl_d.en  = ctrl_wdata_i[EN_BIT];
      ctrl_d.sel = ctrl_wdata_i[SEL_W-1:0];
      if (ctrl_wdata_i[SEL_W-1:0] != ctrl_q.sel) restart_d = 1'b1;
    end
    if (div_wr_i) begin
      div_d     = div_wdata_i;
      restart_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      div_q     <= '0;
      restart_q <= 1'b0;
    end else begin
      ctrl_q    <= ctrl_d;
      div_q     <= div_d;
      restart_q <= restart_d;
    end
  end

  assign ctrl_o    = ctrl_q;
  assign div_o     = div_q;
  assign restart_o = restart_q;

  always_comb begin
    ctrl_rdata_o                = '0;
    ctrl_rdata_o[SEL_W-1:0]     = ctrl_q.sel;
    ctrl_rdata_o[EN_BIT]        = ctrl_q.en;
    ctrl_rdata_o[BUSY_BIT]      = ctrl_q.en;
  end

  // R2: busy readback follows the enable bit of the last control write
  assert_busy_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr_i |=> ctrl_rdata_o[BUSY_BIT] == $past(ctrl_wdata_i[EN_BIT]));

  // R11: a divider write always schedules a phase restart
  assert_div_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
    div_wr_i |=> restart_o);
endmodule

// File: rtl/fracclk_srcsel.sv
module fracclk_srcsel
  import fracclk_pkg::*;
#(
  parameter logic [(1<<SEL_W)-1:0] GND_MASK = 16'hFC01
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [(1<<SEL_W)-1:0]  src_i,
  input  logic [SEL_W-1:0]       sel_i,
  output logic                   tick_o
);
  localparam int NUM_SRC = 1 << SEL_W;

  logic [NUM_SRC-1:0] live;

  // slot 0 is ground whatever the mask says
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_slot
    if (s == 0 || GND_MASK[s]) begin : g_gnd
      assign live[s] = 1'b0;
    end else begin : g_wire
      assign live[s] = src_i[s];
    end
  end

  assign tick_o = live[sel_i];

  logic unused_src;
  assign unused_src = ^(src_i & GND_MASK) ^ src_i[0];

  // R5: a grounded slot never delivers a tick downstream
  assert_gnd_slot_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i == '0 || GND_MASK[sel_i]) |-> !tick_o);
endmodule

// File: rtl/fracclk_phase.sv
module fracclk_phase
  import fracclk_pkg::*;
#(
  parameter int INT_BITS  = 8,
  parameter int FRAC_BITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic             tick_in_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  localparam int W = INT_BITS + FRAC_BITS;

  if (W == 0) begin : g_pass
    logic out_q, out_d;

    assign out_d = en_i & tick_in_i;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_q <= 1'b0;
      else        out_q <= out_d;
    end

    assign tick_o = out_q;

    logic unused_pass;
    assign unused_pass = ^{div_i, clr_i};

    // R10: every enabled source tick passes straight through
    assert_pass_through_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && tick_in_i) |=> tick_o);
  end else begin : g_frac
    localparam int AW = W + 1;
    localparam logic [AW-1:0] STEP = AW'(1) << FRAC_BITS;

    logic [W-1:0]  dval;
    logic [AW-1:0] dwide, acc_q, acc_d, sum;
    logic          out_q, fire_d, stopped;

    assign dval    = div_i[INT_LSB+INT_BITS-1 -: W];
    assign dwide   = {1'b0, dval};
    assign stopped = !en_i || clr_i || (dval == '0);
    assign sum     = acc_q + STEP;

    always_comb begin
      acc_d  = acc_q;
      fire_d = 1'b0;
      if (stopped) begin
        acc_d = '0;
      end else if (tick_in_i) begin
        if (dwide <= STEP) begin
          fire_d = 1'b1;
          acc_d  = '0;
        end else if (sum >= dwide) begin
          fire_d = 1'b1;
          acc_d  = sum - dwide;
        end else begin
          acc_d  = sum;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc_q <= '0;
        out_q <= 1'b0;
      end else begin
        acc_q <= acc_d;
        out_q <= fire_d;
      end
    end

    assign tick_o = out_q;

    logic unused_div;
    assign unused_div = ^div_i;

    // R7: the phase never reaches the divider while running
    assert_acc_below_div_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!stopped && dwide > STEP) |-> acc_q < dwide);

    // R8: a zero divider field stops the output
    assert_zero_div_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (dval == '0) |=> !tick_o);

    // R9: ratios at or below one fire on every source tick
    assert_fast_ratio_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!stopped && tick_in_i && dwide <= STEP) |=> tick_o);
  end

  // R3: no output follows a disabled cycle
  assert_disabled_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !tick_o);
endmodule

// File: rtl/fracclk_gen.sv
module fracclk_gen
  import fracclk_pkg::*;
#(
  parameter int              INT_BITS  = 8,
  parameter int              FRAC_BITS = 8,
  parameter logic [15:0]     GND_MASK  = 16'hFC01
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] src_tick_i,
  input  logic        ctrl_wr_i,
  input  logic [7:0]  ctrl_wdata_i,
  input  logic        div_wr_i,
  input  logic [31:0] div_wdata_i,
  output logic [7:0]  ctrl_rdata_o,
  output logic [31:0] div_rdata_o,
  output logic        tick_o
);
  // asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  ctrl_fields_t     ctrl;
  logic [DIV_W-1:0] div_word;
  logic             restart;
  logic             sel_tick;

  fracclk_regs u_regs (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .ctrl_wr_i    (ctrl_wr_i),
    .ctrl_wdata_i (ctrl_wdata_i),
    .div_wr_i     (div_wr_i),
    .div_wdata_i  (div_wdata_i),
    .ctrl_o       (ctrl),
    .div_o        (div_word),
    .restart_o    (restart),
    .ctrl_rdata_o (ctrl_rdata_o)
  );

  fracclk_srcsel #(.GND_MASK(GND_MASK)) u_srcsel (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .src_i  (src_tick_i),
    .sel_i  (ctrl.sel),
    .tick_o (sel_tick)
  );

  fracclk_phase #(.INT_BITS(INT_BITS), .FRAC_BITS(FRAC_BITS)) u_phase (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .en_i      (ctrl.en),
    .clr_i     (restart),
    .tick_in_i (sel_tick),
    .div_i     (div_word),
    .tick_o    (tick_o)
  );

  assign div_rdata_o = div_word;
endmodule

// File: tb/tb_fracclk_gen.sv
`timescale 1ns/1ps
module tb_fracclk_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] src_tick = '0;
  logic        ctrl_wr = 1'b0;
  logic [7:0]  ctrl_wdata = '0;
  logic        div_wr = 1'b0;
  logic [31:0] div_wdata = '0;
  logic [7:0]  ctrl_rdata, ctrl_rdata_p;
  logic [31:0] div_rdata, div_rdata_p;
  logic        tick, tick_p;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  fracclk_gen dut (
    .clk(clk), .rst_n(rst_n), .src_tick_i(src_tick),
    .ctrl_wr_i(ctrl_wr), .ctrl_wdata_i(ctrl_wdata),
    .div_wr_i(div_wr), .div_wdata_i(div_wdata),
    .ctrl_rdata_o(ctrl_rdata), .div_rdata_o(div_rdata), .tick_o(tick));

  fracclk_gen #(.INT_BITS(0), .FRAC_BITS(0)) dut_pass (
    .clk(clk), .rst_n(rst_n), .src_tick_i(src_tick),
    .ctrl_wr_i(ctrl_wr), .ctrl_wdata_i(ctrl_wdata),
    .div_wr_i(div_wr), .div_wdata_i(div_wdata),
    .ctrl_rdata_o(ctrl_rdata_p), .div_rdata_o(div_rdata_p), .tick_o(tick_p));

  task automatic chk(input longint act, input longint exp, input string req);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [7:0] v);
    @(negedge clk); ctrl_wr = 1'b1; ctrl_wdata = v;
    @(negedge clk); ctrl_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr_div(input logic [31:0] v);
    @(negedge clk); div_wr = 1'b1; div_wdata = v;
    @(negedge clk); div_wr = 1'b0;
    @(negedge clk);
  endtask

  // n source pulses on the slots in pat; counts ticks of both instances
  task automatic pulses(input int n, input logic [15:0] pat,
                        output int cnt, output int cnt_p);
    cnt = 0; cnt_p = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); src_tick = pat;
      @(negedge clk); src_tick = '0;
      cnt += int'(tick); cnt_p += int'(tick_p);
    end
  endtask

  // expected output count from the rate rule, D = ip*256 + fp
  function automatic int expect_cnt(input int n, input int ip, input int fp);
    int d = ip * 256 + fp;
    if (d == 0) return 0;
    if (d <= 256) return n;
    return (n * 256) / d;
  endfunction

  task automatic t_reset;
    chk(ctrl_rdata, 8'h00, "R1 ctrl reset");
    chk(div_rdata, 0, "R1 div reset");
    chk(tick, 0, "R1 tick reset");
  endtask

  task automatic t_busy;
    wr_ctrl(8'h81); chk(ctrl_rdata, 8'h01, "R2 busy without enable");
    wr_ctrl(8'h11); chk(ctrl_rdata, 8'h91, "R2 busy with enable");
    wr_ctrl(8'hF1); chk(ctrl_rdata, 8'h91, "R2 bits 6:5 ignored");
  endtask

  task automatic t_disabled;
    int c, cp;
    wr_ctrl(8'h01); wr_div(32'h0000_1000);
    pulses(8, 16'hFFFF, c, cp);
    chk(c, 0, "R3 disabled divider instance");
    chk(cp, 0, "R3 disabled pass instance");
  endtask

  task automatic t_select;
    int c, cp;
    wr_ctrl(8'h11); wr_div(32'h0000_1000);
    pulses(8, 16'h0002, c, cp);
    chk(c, 8, "R4 R9 slot 1 ratio one");
    pulses(8, 16'hFFFD, c, cp);
    chk(c, 0, "R4 other slots ignored");
  endtask

  task automatic t_ground;
    int c, cp;
    wr_ctrl(8'h10); pulses(6, 16'hFFFF, c, cp);
    chk(c, 0, "R5 slot 0 ground");
    wr_ctrl(8'h1C); pulses(6, 16'hFFFF, c, cp);
    chk(c, 0, "R5 masked slot 12");
    chk(cp, 0, "R5 masked slot pass instance");
  endtask

  task automatic t_rate;
    int c, cp;
    wr_ctrl(8'h11);
    wr_div(32'h0000_2800); pulses(20, 16'h0002, c, cp);
    chk(c, expect_cnt(20, 2, 128), "R7 ratio 2.5");
    wr_div(32'h0000_3000); pulses(30, 16'h0002, c, cp);
    chk(c, expect_cnt(30, 3, 0), "R7 ratio 3.0");
    wr_div(32'h0000_1400); pulses(20, 16'h0002, c, cp);
    chk(c, expect_cnt(20, 1, 64), "R7 ratio 1.25");
    chk(cp, 20, "R10 pass ignores divider");
  endtask

  task automatic t_field;
    int c, cp;
    wr_ctrl(8'h11);
    wr_div(32'hFFF0_000F);
    chk(div_rdata, 32'hFFF0_000F, "R6 readback whole word");
    pulses(10, 16'h0002, c, cp);
    chk(c, 0, "R8 zero field stops output");
    chk(cp, 10, "R10 pass with zero divider");
    wr_div(32'hF000_280A); pulses(20, 16'h0002, c, cp);
    chk(c, expect_cnt(20, 2, 128), "R6 outside bits ignored");
  endtask

  task automatic t_fast;
    int c, cp;
    wr_ctrl(8'h11); wr_div(32'h0000_0800);
    pulses(12, 16'h0002, c, cp);
    chk(c, expect_cnt(12, 0, 128), "R9 ratio 0.5 saturates");
  endtask

  task automatic t_restart;
    int c, cp;
    wr_ctrl(8'h11); wr_div(32'h0000_2800);
    pulses(2, 16'h0002, c, cp);
    chk(c, 0, "R11 partial period");
    wr_div(32'h0000_2800); pulses(3, 16'h0002, c, cp);
    chk(c, 1, "R11 divider write restarts");
    wr_div(32'h0000_2800); pulses(2, 16'h0006, c, cp);
    wr_ctrl(8'h12); pulses(3, 16'h0006, c, cp);
    chk(c, 1, "R11 select change restarts");
  endtask

  task automatic t_latency;
    int c, cp;
    wr_ctrl(8'h11); wr_div(32'h0000_1000);
    @(negedge clk); src_tick = 16'h0002;
    chk(tick, 0, "R12 no tick before edge");
    @(negedge clk); src_tick = '0;
    chk(tick, 1, "R12 tick one cycle later");
    @(negedge clk);
    chk(tick, 0, "R12 single cycle pulse");
    pulses(1, 16'h0000, c, cp);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_busy;
    t_disabled;
    t_select;
    t_ground;
    t_rate;
    t_field;
    t_fast;
    t_restart;
    t_latency;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule